// File: doc/BRIEF.md
# Command-Decoding Two-Wire Register Target

This block is the serial-bus front end of a measurement device. It listens on a two-wire bus (clock line plus open-drain data line, SMBus/I2C-compatible, about 10 kHz to 400 kHz). It answers one 7-bit address, which a three-level board strap picks. It also decodes a small set of one-byte command codes. One code reads or writes a 16-bit configuration word. Three other codes all return the same 16-bit result word, which the measurement datapath drives into the block. The configuration word is driven out to that datapath. A 2-bit measurement-select output carries only defined mode values. A one-cycle strobe tells the alert logic that a result has been read out.

Both bus lines pass through a synchronizer and a glitch filter before any edge or start/stop decision is made. A single state machine tracks the frame. It has these states:
- IDLE.
- Address receive and its acknowledge: ADDR, ADDR_ACK.
- Command receive and its acknowledge: CMD, CMD_ACK.
- Write low byte and acknowledge: WLO, WLO_ACK.
- Write high byte and acknowledge: WHI, WHI_ACK.
- COMMIT_WAIT, which waits for stop.
- Read low byte and master acknowledge: RLO, RLO_ACK.
- Read high byte and master acknowledge: RHI, RHI_ACK.
- SKIP, a passive wait for the next start or stop.

Transitions:
- A start from any state goes to ADDR. A stop from any state goes to IDLE.
- After 8 received bits the next clock fall either acknowledges and moves to the matching ACK state, or goes to SKIP.
- From the ACK states: ADDR_ACK goes to CMD (write) or RLO (read). CMD_ACK goes to WLO (configuration code) or SKIP (a result code, which waits for a repeated start). WLO_ACK goes to WHI. WHI_ACK goes to COMMIT_WAIT.
- RLO and RHI each go to their ACK state after 8 driven bits.
- In RLO_ACK, a master acknowledge leads to RHI and a not-acknowledge leads to SKIP. RHI_ACK always goes to SKIP.

Top module: `smb_cmd_target`

## Requirements
- R1: The answered address depends on the strap input. Strap 2'b00 (tied low) answers 7'h70. Strap 2'b01 (open) answers 7'h72. Strap 2'b10 (tied high) answers 7'h76. Strap 2'b11 answers no address.
- R2: An address byte that does not match is not acknowledged. The block does not drive SDA for the rest of that frame, and no register changes.
- R3: Write frame: address with R/W bit 0, command 8'hD0, then a low data byte and a high data byte, each sent MSB first. All four bytes are acknowledged, and the configuration output becomes {high, low}.
- R4: Read frame: address (write) and 8'hD0, then a repeated start, then address with R/W bit 1. This returns the configuration word low byte first, each byte MSB first.
- R5: Command codes 8'h8B, 8'h8C and 8'h96, used in the same read frame, each return the result input word. The word is captured when the read address is acknowledged.
- R6: Any command code other than 8'hD0, 8'h8B, 8'h8C and 8'h96 is not acknowledged and changes no register. This includes 8'hD2 to 8'hD5, 8'hD7 and 8'hD8.
- R7: A configuration write takes effect only after both data bytes were acknowledged and a stop follows. A frame cut off by an early stop or by a start leaves the configuration unchanged.
- R8: The measurement-select output follows configuration bits [7:6] of each committed word, except that the value 2'b11 is never taken. In that case the previous selection is kept, while the word itself is still stored.
- R9: After the master's acknowledge bit for the high byte of a result read (codes 8'h8B/8'h8C/8'h96), read_done_o is high for exactly one clock. A configuration read never raises it.
- R10: After reset, the configuration output is 16'h0000 and the selection output is 2'b00. SDA is released and read_done_o is low.
- R11: SCL pulses shorter than FILT_CYC clock cycles are ignored and do not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bus rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain) |
| strap_i | input | 2 | Address strap: 00 low, 01 open, 10 high, 11 invalid |
| result_i | input | 16 | Result word from the measurement datapath |
| cfg_o | output | 16 | Committed configuration word |
| meas_sel_o | output | 2 | Defined measurement selection from cfg bits [7:6] |
| read_done_o | output | 1 | One-cycle strobe after a completed result read |

## Verification
A table of write and read frames drives the main function. The frames carry distinct data words, so low/high byte order and bit order stay apart. Different result words go to each of the three result codes, which shows that all three alias the one input. A configuration read is placed beside each result read, which separates the two read sources and the strobe rule. The patterns also cover each strap level against matching and mismatched addresses, the reserved and unknown codes, frames cut off after one byte or by a repeated start, a word whose mode field is 2'b11, and a write with single-cycle SCL glitches. These tell apart the guards on address, command, commit and mode.

// File: rtl/smb_cmd_pkg.sv
package smb_cmd_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int MODE_LSB = 6;
    localparam int MODE_W   = 2;

    localparam logic [BYTE_W-1:0] CMD_CFG   = 8'hD0;
    localparam logic [BYTE_W-1:0] CMD_RES_A = 8'h8B;
    localparam logic [BYTE_W-1:0] CMD_RES_B = 8'h8C;
    localparam logic [BYTE_W-1:0] CMD_RES_C = 8'h96;
    localparam logic [MODE_W-1:0] MODE_UNDEF = 2'b11;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_OPEN = 2'b01,
        STRAP_HIGH = 2'b10,
        STRAP_BAD  = 2'b11
    } strap_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WLO,
        S_WLO_ACK,
        S_WHI,
        S_WHI_ACK,
        S_COMMIT_WAIT,
        S_RLO,
        S_RLO_ACK,
        S_RHI,
        S_RHI_ACK,
        S_SKIP
    } tgt_state_e;

    function automatic logic cmd_is_result(input logic [BYTE_W-1:0] c);
        return (c == CMD_RES_A) || (c == CMD_RES_B) || (c == CMD_RES_C);
    endfunction

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == CMD_CFG) || cmd_is_result(c);
    endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_DEPTH = 2,
    parameter int FILT_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_DEPTH-1:0] sync_q;
    logic [CW-1:0]         cnt_q;
    logic                  smp;

    assign smp = sync_q[SYNC_DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], line_i};
            if (smp == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                line_o <= smp;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smb_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_s,
    input  logic [6:0]        my_addr,
    input  logic              addr_ok,
    input  logic [WORD_W-1:0] cfg_val,
    input  logic [WORD_W-1:0] res_val,
    output logic              sda_oe,
    output logic              wr_commit,
    output logic [WORD_W-1:0] wr_word,
    output logic              rd_done,
    output tgt_state_e        state_o
);

    tgt_state_e        state_q, state_d;
    logic [3:0]        bitcnt_q, bitcnt_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic [BYTE_W-1:0] txsh_q, txsh_d;
    logic [WORD_W-1:0] txword_q, txword_d;
    logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
    logic [BYTE_W-1:0] cmd_q, cmd_d;
    logic              cmdok_q, cmdok_d;
    logic              rw_q, rw_d;
    logic              oe_q, oe_d;
    logic              done_q, done_d;
    logic              commit_q, commit_d;
    logic              addr_hit;

    assign addr_hit = addr_ok && (shreg_q[7:1] == my_addr);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txsh_q   <= '0;
            txword_q <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            cmd_q    <= '0;
            cmdok_q  <= 1'b0;
            rw_q     <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            shreg_q  <= shreg_d;
            txsh_q   <= txsh_d;
            txword_q <= txword_d;
            lo_q     <= lo_d;
            hi_q     <= hi_d;
            cmd_q    <= cmd_d;
            cmdok_q  <= cmdok_d;
            rw_q     <= rw_d;
            oe_q     <= oe_d;
            done_q   <= done_d;
            commit_q <= commit_d;
        end
    end

    // Next state and next output values
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        shreg_d  = shreg_q;
        txsh_d   = txsh_q;
        txword_d = txword_q;
        lo_d     = lo_q;
        hi_d     = hi_q;
        cmd_d    = cmd_q;
        cmdok_d  = cmdok_q;
        rw_d     = rw_q;
        oe_d     = oe_q;
        done_d   = 1'b0;
        commit_d = 1'b0;

        if (stop_ev) begin
            commit_d = (state_q == S_COMMIT_WAIT);
            state_d  = S_IDLE;
            oe_d     = 1'b0;
            cmdok_d  = 1'b0;
        end else if (start_ev) begin
            state_d  = S_ADDR;
            bitcnt_d = '0;
            oe_d     = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_SKIP, S_COMMIT_WAIT: begin
                end

                S_ADDR, S_CMD, S_WLO, S_WHI: begin
                    if (scl_rise && bitcnt_q < 4'd8) begin
                        shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
                        bitcnt_d = bitcnt_q + 4'd1;
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        bitcnt_d = '0;
                        if (state_q == S_ADDR) begin
                            if (addr_hit && (!shreg_q[0] || cmdok_q)) begin
                                oe_d    = 1'b1;
                                rw_d    = shreg_q[0];
                                state_d = S_ADDR_ACK;
                                if (!shreg_q[0]) begin
                                    cmdok_d = 1'b0;
                                end else begin
                                    txword_d = (cmd_q == CMD_CFG) ? cfg_val : res_val;
                                end
                            end else begin
                                state_d = S_SKIP;
                            end
                        end else if (state_q == S_CMD) begin
                            if (cmd_known(shreg_q)) begin
                                oe_d    = 1'b1;
                                cmd_d   = shreg_q;
                                cmdok_d = 1'b1;
                                state_d = S_CMD_ACK;
                            end else begin
                                state_d = S_SKIP;
                            end
                        end else if (state_q == S_WLO) begin
                            lo_d    = shreg_q;
                            oe_d    = 1'b1;
                            state_d = S_WLO_ACK;
                        end else begin
                            hi_d    = shreg_q;
                            oe_d    = 1'b1;
                            state_d = S_WHI_ACK;
                        end
                    end
                end

                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_d = '0;
                        if (rw_q) begin
                            txsh_d  = txword_q[BYTE_W-1:0];
                            oe_d    = ~txword_q[BYTE_W-1];
                            state_d = S_RLO;
                        end else begin
                            oe_d    = 1'b0;
                            state_d = S_CMD;
                        end
                    end
                end

                S_CMD_ACK: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        state_d = (cmd_q == CMD_CFG) ? S_WLO : S_SKIP;
                    end
                end

                S_WLO_ACK: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        state_d = S_WHI;
                    end
                end

                S_WHI_ACK: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        state_d = S_COMMIT_WAIT;
                    end
                end

                S_RLO, S_RHI: begin
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            oe_d    = 1'b0;
                            state_d = (state_q == S_RLO) ? S_RLO_ACK : S_RHI_ACK;
                        end else begin
                            txsh_d   = {txsh_q[BYTE_W-2:0], 1'b0};
                            oe_d     = ~txsh_q[BYTE_W-2];
                            bitcnt_d = bitcnt_q + 4'd1;
                        end
                    end
                end

                S_RLO_ACK: begin
                    if (scl_rise && sda_s) begin
                        state_d = S_SKIP;
                    end else if (scl_fall) begin
                        bitcnt_d = '0;
                        txsh_d   = txword_q[WORD_W-1:BYTE_W];
                        oe_d     = ~txword_q[WORD_W-1];
                        state_d  = S_RHI;
                    end
                end

                S_RHI_ACK: begin
                    if (scl_rise) begin
                        done_d  = cmd_is_result(cmd_q);
                        state_d = S_SKIP;
                    end
                end

                default: begin
                    state_d = S_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe    = oe_q;
        wr_commit = commit_q;
        wr_word   = {hi_q, lo_q};
        rd_done   = done_q;
        state_o   = state_q;
    end

endmodule

// File: rtl/smb_cmd_target.sv
module smb_cmd_target
    import smb_cmd_pkg::*;
#(
    parameter int         SYNC_DEPTH = 2,
    parameter int         FILT_CYC   = 3,
    parameter logic [6:0] ADDR_LOW   = 7'h70,
    parameter logic [6:0] ADDR_OPEN  = 7'h72,
    parameter logic [6:0] ADDR_HIGH  = 7'h76
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [1:0]  strap_i,
    input  logic [15:0] result_i,
    output logic [15:0] cfg_o,
    output logic [1:0]  meas_sel_o,
    output logic        read_done_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic [6:0]        my_addr;
    logic              addr_ok;
    logic              commit_w;
    logic [WORD_W-1:0] word_w;
    tgt_state_e        state_w;
    logic [WORD_W-1:0] cfg_q;
    logic [MODE_W-1:0] meas_q;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        smb_line_filter #(
            .SYNC_DEPTH(SYNC_DEPTH),
            .FILT_CYC  (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    smb_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (filt_lines[1]),
        .sda_f   (filt_lines[0]),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    always_comb begin
        my_addr = ADDR_LOW;
        addr_ok = 1'b1;
        unique case (strap_e'(strap_i))
            STRAP_LOW:  my_addr = ADDR_LOW;
            STRAP_OPEN: my_addr = ADDR_OPEN;
            STRAP_HIGH: my_addr = ADDR_HIGH;
            STRAP_BAD:  addr_ok = 1'b0;
            default:    addr_ok = 1'b0;
        endcase
    end

    smb_target_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (filt_lines[0]),
        .my_addr  (my_addr),
        .addr_ok  (addr_ok),
        .cfg_val  (cfg_q),
        .res_val  (result_i),
        .sda_oe   (sda_oe_o),
        .wr_commit(commit_w),
        .wr_word  (word_w),
        .rd_done  (read_done_o),
        .state_o  (state_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            meas_q <= '0;
        end else if (commit_w) begin
            cfg_q <= word_w;
            if (word_w[MODE_LSB +: MODE_W] != MODE_UNDEF) begin
                meas_q <= word_w[MODE_LSB +: MODE_W];
            end
        end
    end

    assign cfg_o      = cfg_q;
    assign meas_sel_o = meas_q;

endmodule

// File: rtl/smb_cmd_target_chk.sv
module smb_cmd_target_chk
    import smb_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe_o,
    input logic        read_done_o,
    input logic [15:0] cfg_o,
    input logic [1:0]  meas_sel_o,
    input logic        commit_w,
    input tgt_state_e  state_w
);

    // R9: strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |=> !read_done_o);

    // R9: strobe only after the final acknowledge, machine then passive
    a_r9_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |-> (state_w == S_SKIP));

    // R7: configuration moves only on a commit
    a_r7_cfg_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_w |=> $stable(cfg_o));

    // R8: undefined selection never reaches the output
    a_r8_mode_defined: assert property (@(posedge clk) disable iff (!rst_n)
        meas_sel_o != MODE_UNDEF);

    // R2: idle bus is never driven
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == S_IDLE) |-> !sda_oe_o);

    // R6: rejected frames are never driven
    a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == S_SKIP) |-> !sda_oe_o);

endmodule

bind smb_cmd_target smb_cmd_target_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe_o   (sda_oe_o),
    .read_done_o(read_done_o),
    .cfg_o      (cfg_o),
    .meas_sel_o (meas_sel_o),
    .commit_w   (commit_w),
    .state_w    (state_w)
);

// File: tb/smb_cmd_target_tb.sv
module smb_cmd_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NVEC       = 9;

    // vector: {is_read, cmd[7:0], data[15:0], mode[1:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 8'hD0, 16'h1234, 2'b00},
        {1'b1, 8'hD0, 16'h1234, 2'b00},
        {1'b0, 8'hD0, 16'hBE4D, 2'b01},
        {1'b1, 8'hD0, 16'hBE4D, 2'b01},
        {1'b1, 8'h8B, 16'h7F01, 2'b01},
        {1'b1, 8'h8C, 16'h8000, 2'b01},
        {1'b1, 8'h96, 16'h00FF, 2'b01},
        {1'b0, 8'hD0, 16'h00C7, 2'b01},
        {1'b1, 8'hD0, 16'h00C7, 2'b01}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m, sda_m;
    logic        glitch_en;
    logic [1:0]  strap;
    logic [15:0] result;
    logic        dut_oe;
    logic [15:0] cfg_o;
    logic [1:0]  meas_sel;
    logic        rd_done;
    wire         sda_bus = sda_m & ~dut_oe;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_cmd_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (dut_oe),
        .strap_i    (strap),
        .result_i   (result),
        .cfg_o      (cfg_o),
        .meas_sel_o (meas_sel),
        .read_done_o(rd_done)
    );

    always @(posedge clk) if (rd_done) pulses++;

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic s);
        w(Q);
        sda_m = b;
        if (glitch_en) begin
            scl_m = 1'b1; w(1); scl_m = 1'b0;
        end
        w(Q);
        scl_m = 1'b1;
        w(Q);
        s = sda_bus;
        w(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nak);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, nak);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(last, s);
    endtask

    task automatic wr_word(input logic [6:0] a, input logic [7:0] c,
                           input logic [15:0] d, output logic ok);
        logic n0, n1, n2, n3;
        bus_start();
        send_byte({a, 1'b0}, n0);
        send_byte(c, n1);
        send_byte(d[7:0], n2);
        send_byte(d[15:8], n3);
        bus_stop();
        ok = !(n0 | n1 | n2 | n3);
    endtask

    task automatic rd_word(input logic [6:0] a, input logic [7:0] c,
                           output logic [15:0] d, output logic ok);
        logic n0, n1, n2;
        bus_start();
        send_byte({a, 1'b0}, n0);
        send_byte(c, n1);
        bus_start();
        send_byte({a, 1'b1}, n2);
        recv_byte(1'b0, d[7:0]);
        recv_byte(1'b1, d[15:8]);
        bus_stop();
        ok = !(n0 | n1 | n2);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        logic        ok;
        logic [15:0] d;
        int          p0;
        logic        n;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; glitch_en = 1'b0;
        strap = 2'b01; result = 16'h0;
        w(5);
        rst_n = 1'b1;
        w(5);

        // R10 reset state
        chk("R10 cfg", cfg_o, 16'h0000);
        chk("R10 sel", 16'(meas_sel), 16'h0);
        chk("R10 oe", 16'(dut_oe), 16'h0);
        chk("R10 done", 16'(rd_done), 16'h0);

        // Table walk: R3 R4 R5 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic        rd;
            logic [7:0]  c;
            logic [15:0] v;
            logic [1:0]  m;
            rd = VEC[i][26]; c = VEC[i][25:18]; v = VEC[i][17:2]; m = VEC[i][1:0];
            if (!rd) begin
                wr_word(7'h72, c, v, ok);
                chk("R3 write ack", 16'(ok), 16'h1);
                chk("R3 cfg word", cfg_o, v);
                chk("R8 selection", 16'(meas_sel), 16'(m));
            end else begin
                if (c != 8'hD0) result = v;
                p0 = pulses;
                rd_word(7'h72, c, d, ok);
                w(2);
                chk(c == 8'hD0 ? "R4 read ack" : "R5 read ack", 16'(ok), 16'h1);
                chk(c == 8'hD0 ? "R4 cfg read" : "R5 result read", d, v);
                chk("R9 strobe count", 16'(pulses - p0), c == 8'hD0 ? 16'h0 : 16'h1);
            end
        end

        // R1 strap levels
        strap = 2'b00;
        rd_word(7'h70, 8'hD0, d, ok);
        chk("R1 low strap 70", 16'(ok), 16'h1);
        chk("R1 low strap data", d, 16'h00C7);
        rd_word(7'h72, 8'hD0, d, ok);
        chk("R1 low strap rejects 72", 16'(ok), 16'h0);
        strap = 2'b10;
        rd_word(7'h76, 8'hD0, d, ok);
        chk("R1 high strap 76", 16'(ok), 16'h1);
        strap = 2'b11;
        for (int k = 0; k < 3; k++) begin
            logic [6:0] a;
            a = (k == 0) ? 7'h70 : (k == 1) ? 7'h72 : 7'h76;
            bus_start();
            send_byte({a, 1'b0}, n);
            bus_stop();
            chk("R1 invalid strap nack", 16'(n), 16'h1);
        end

        // R2 wrong address: no ack, no change
        strap = 2'b01;
        wr_word(7'h71, 8'hD0, 16'hFFFF, ok);
        chk("R2 wrong addr nack", 16'(ok), 16'h0);
        chk("R2 cfg unchanged", cfg_o, 16'h00C7);
        result = 16'h1111;
        p0 = pulses;
        rd_word(7'h73, 8'h8B, d, ok);
        w(2);
        chk("R2 wrong addr read data", d, 16'hFFFF);
        chk("R2 no strobe", 16'(pulses - p0), 16'h0);

        // R6 reserved and unknown codes
        for (int k = 0; k < 7; k++) begin
            logic [7:0] c;
            c = (k < 4) ? 8'(8'hD2 + k) : (k == 4) ? 8'hD7 : (k == 5) ? 8'hD8 : 8'h00;
            bus_start();
            send_byte({7'h72, 1'b0}, n);
            send_byte(c, n);
            chk("R6 reserved code nack", 16'(n), 16'h1);
            send_byte(8'hC0, n);
            send_byte(8'hFF, n);
            bus_stop();
            chk("R6 cfg unchanged", cfg_o, 16'h00C7);
            chk("R6 selection unchanged", 16'(meas_sel), 16'h1);
        end

        // R7 aborted writes
        bus_start();
        send_byte({7'h72, 1'b0}, n);
        send_byte(8'hD0, n);
        send_byte(8'h80, n);
        bus_stop();
        chk("R7 one byte then stop", cfg_o, 16'h00C7);
        bus_start();
        send_byte({7'h72, 1'b0}, n);
        send_byte(8'hD0, n);
        send_byte(8'h80, n);
        send_byte(8'h55, n);
        bus_start();
        bus_stop();
        chk("R7 cut by start", cfg_o, 16'h00C7);
        chk("R7 selection kept", 16'(meas_sel), 16'h1);

        // R11 SCL glitches during a write
        glitch_en = 1'b1;
        wr_word(7'h72, 8'hD0, 16'h5A0F, ok);
        glitch_en = 1'b0;
        chk("R11 glitched write ack", 16'(ok), 16'h1);
        chk("R11 glitched write cfg", cfg_o, 16'h5A0F);
        chk("R8 selection after 00", 16'(meas_sel), 16'h0);

        finished = 1'b1;
        report();
    end

endmodule